// File: doc/BRIEF.md
# Time-Encoded Chunk Receiver

This block rebuilds a parallel data block from a set of data wires on which each value is carried by timing, not by level. A shared start/skip wire opens a block. Each data wire then carries its chunks one after another. The value of a chunk is the number of clock cycles between a reference transition and the wire's next transition. Each wire changes state once per chunk. A transition in either direction counts as one event, so switching activity does not depend on the data.

The shared wire has two meanings. A transition on it opens a new block when no chunk of the current block is still outstanding. If chunks are outstanding, the same transition is a skip command. A skip command fills every outstanding chunk with a skip value and completes the block. The skip value is zero in zero-skip mode, or each wire's most recently received chunk in last-value mode. When every chunk is known, the block drives a one-cycle ready pulse. The reassembled block stays on its output until the next block opens. A sticky error flag records data transitions that arrive outside an open block, and skip commands given in the mode that has no skip.

Top module: `pulse_gap_rx`

## Requirements
- R1: A level change on any input wire, rising or falling, is one event. The event is detected at the first clock edge that sees the wire differ from its value one cycle earlier.
- R2: The first chunk on each wire takes the number of cycles from the new-block event to that wire's first event. It is 0 when both events fall on the same edge.
- R3: Later chunks on a wire are stored in arrival order. Each takes the number of cycles since the previous event on the same wire, minus one. Chunk j of wire w occupies `blk_data[(w*CPW+j)*CW +: CW]`.
- R4: A start/skip event opens a new block when no block is open or every chunk of the open block is filled. `mode_sel` is sampled at that edge: 0 basic, 1 zero-skip, 2 last-value, 3 same as basic.
- R5: In zero-skip mode, a start/skip event with chunks outstanding writes 0 into every outstanding chunk and completes the block.
- R6: In last-value mode, the skip command writes into each outstanding chunk the value most recently received by a transition on that wire, in this block or an earlier one.
- R7: `blk_ready` is high for exactly one cycle. It rises at the second clock edge after the event that fills the last chunk.
- R8: `blk_data` does not change while no block is open, until the next new-block event.
- R9: A data event on a wire with no open block, or on a wire whose chunks are all filled, changes no chunk and sets `proto_err`. The flag stays set until reset.
- R10: In basic mode, a start/skip event with chunks outstanding changes nothing except setting `proto_err`. The block then completes normally.
- R11: Synchronous reset clears `blk_data`, `blk_ready`, `proto_err` and every wire's last-value memory to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Skip mode, sampled when a block opens |
| rs_wire | input | 1 | Shared start/skip wire, transition coded |
| data_wire | input | LANES | Data wires, transition coded |
| blk_data | output | LANES*CPW*CW | Reassembled block |
| blk_ready | output | 1 | One-cycle block-complete pulse |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Directed blocks separate the timing rules from each other:
- A first chunk of 0 arrives on the same edge as the start event.
- A chunk of 15 and a following 0 on the same wire separate the first-chunk count from the minus-one count of later chunks.
- An all-zero block in zero-skip mode places the skip command one cycle after the start.
- Tails equal to earlier values show whether last-value mode reads the wire's own history.

Random blocks in all four modes, with values biased towards skippable tails, exercise many mixes of skipped and transmitted wires. In these blocks, the exact cycle of the ready pulse exposes off-by-one errors in completion.

The error stimuli are a stray data toggle while idle and a premature start/skip in basic mode. They check that the protocol-error cases leave the block unchanged. A last-value block run after reset confirms that reset clears the per-wire history.

// File: rtl/pulse_gap_pkg.sv
package pulse_gap_pkg;
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ZERO = 2'd1,
    FILL_LAST = 2'd2,
    FILL_RSVD = 2'd3
  } fill_mode_e;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);
  logic [W-1:0] lvl_q;

  // copy follows the wire at all times, so reset never creates a false event
  always_ff @(posedge clk) lvl_q <= lvl;

  assign evt = lvl ^ lvl_q;
endmodule

// File: rtl/gap_lane.sv
module gap_lane #(
  parameter int CW  = 4,
  parameter int CPW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tog,
  input  logic              open_q,
  input  logic              blk_start,
  input  logic              fill,
  input  logic              fill_last,
  output logic [CPW*CW-1:0] chunks,
  output logic              done,
  output logic              stray
);
  localparam int IW = $clog2(CPW + 1);

  logic [CPW-1:0][CW-1:0] slot_q;
  logic [IW-1:0]          idx_q;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          last_q;

  logic [IW-1:0] cur_idx;
  logic [IW-1:0] post_idx;
  logic          done_eff;
  logic          accept;
  logic [CW-1:0] cap_val;
  logic [CW-1:0] fill_val;

  assign done     = (idx_q == IW'(CPW));
  assign done_eff = blk_start ? 1'b0 : done;
  assign cur_idx  = blk_start ? '0 : idx_q;
  assign accept   = tog && (open_q || blk_start) && !done_eff;
  assign stray    = tog && !accept;
  assign post_idx = cur_idx + IW'(accept);
  assign cap_val  = blk_start ? '0 : cnt_q;
  assign fill_val = fill_last ? (accept ? cap_val : last_q) : '0;
  assign chunks   = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (blk_start) begin
        idx_q <= '0;
        cnt_q <= CW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (accept) begin
        last_q <= cap_val;
        cnt_q  <= '0;
        idx_q  <= post_idx;
      end
      for (int j = 0; j < CPW; j++) begin
        if (accept && (IW'(j) == cur_idx)) slot_q[j] <= cap_val;
        if (fill && (IW'(j) >= post_idx))  slot_q[j] <= fill_val;
      end
      if (fill) idx_q <= IW'(CPW);
    end
  end
endmodule

// File: rtl/block_sequencer.sv
module block_sequencer
  import pulse_gap_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rs_evt,
  input  logic [1:0]       mode_sel,
  input  logic [LANES-1:0] lane_done,
  input  logic [LANES-1:0] lane_stray,
  output logic             open_q,
  output logic             blk_start,
  output logic             fill,
  output logic             fill_last,
  output logic             ready_q,
  output logic             err_q
);
  fill_mode_e mode_q;
  logic all_done;
  logic pending;
  logic skip_req;
  logic bad_skip;

  assign all_done  = &lane_done;
  assign pending   = open_q && !all_done;
  assign blk_start = rs_evt && !pending && !rst;
  assign skip_req  = rs_evt && pending;
  assign fill      = skip_req && (mode_q == FILL_ZERO || mode_q == FILL_LAST);
  assign bad_skip  = skip_req && !fill;
  assign fill_last = (mode_q == FILL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      mode_q  <= FILL_NONE;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= open_q && all_done;
      err_q   <= err_q | bad_skip | (|lane_stray);
      if (blk_start) begin
        open_q <= 1'b1;
        mode_q <= fill_mode_e'(mode_sel);
      end else if (all_done) begin
        open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pulse_gap_rx.sv
module pulse_gap_rx #(
  parameter int LANES = 16,
  parameter int CW    = 4,
  parameter int CPW   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode_sel,
  input  logic                      rs_wire,
  input  logic [LANES-1:0]          data_wire,
  output logic [LANES*CPW*CW-1:0]   blk_data,
  output logic                      blk_ready,
  output logic                      proto_err
);
  localparam int LANE_W = CPW * CW;
  localparam int BLK_W  = LANES * LANE_W;

  logic             rs_evt;
  logic [LANES-1:0] d_evt;
  logic [LANES-1:0] lane_done;
  logic [LANES-1:0] lane_stray;
  logic             open_q;
  logic             blk_start;
  logic             fill;
  logic             fill_last;
  logic [BLK_W-1:0] blk_int;

  edge_sense #(.W(1)) u_rs_edge (
    .clk(clk), .lvl(rs_wire), .evt(rs_evt)
  );

  edge_sense #(.W(LANES)) u_data_edge (
    .clk(clk), .lvl(data_wire), .evt(d_evt)
  );

  block_sequencer #(.LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .rs_evt(rs_evt), .mode_sel(mode_sel),
    .lane_done(lane_done), .lane_stray(lane_stray),
    .open_q(open_q), .blk_start(blk_start), .fill(fill),
    .fill_last(fill_last), .ready_q(blk_ready), .err_q(proto_err)
  );

  for (genvar w = 0; w < LANES; w++) begin : g_lane
    gap_lane #(.CW(CW), .CPW(CPW)) u_lane (
      .clk(clk), .rst(rst), .tog(d_evt[w]), .open_q(open_q),
      .blk_start(blk_start), .fill(fill), .fill_last(fill_last),
      .chunks(blk_int[w*LANE_W +: LANE_W]),
      .done(lane_done[w]), .stray(lane_stray[w])
    );
  end

  assign blk_data = blk_int;
endmodule

// File: rtl/pulse_gap_rx_chk.sv
module pulse_gap_rx_chk #(
  parameter int LANES = 16,
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             rs_evt,
  input logic [LANES-1:0] d_evt,
  input logic             open_q,
  input logic [BLK_W-1:0] blk_data,
  input logic             blk_ready,
  input logic             proto_err
);
  assert_ready_single_R7: assert property (@(posedge clk) disable iff (rst)
    blk_ready |=> !blk_ready);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_stray_flags_R9: assert property (@(posedge clk) disable iff (rst)
    ((|d_evt) && !open_q && !rs_evt) |=> proto_err);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !rs_evt) |=> $stable(blk_data));

  assert_start_opens_R4: assert property (@(posedge clk) disable iff (rst)
    (rs_evt && !open_q) |=> open_q);
endmodule

bind pulse_gap_rx pulse_gap_rx_chk #(.LANES(LANES), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .rs_evt(rs_evt), .d_evt(d_evt), .open_q(open_q),
  .blk_data(blk_data), .blk_ready(blk_ready), .proto_err(proto_err)
);

// File: tb/pulse_gap_rx_test.sv
module pulse_gap_rx_test;
  localparam int LANES = 16;
  localparam int CW    = 4;
  localparam int CPW   = 2;
  localparam int BLK_W = LANES * CPW * CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic rs_wire = 1'b0;
  logic [LANES-1:0] data_wire = '0;
  logic [BLK_W-1:0] blk_data;
  logic blk_ready;
  logic proto_err;

  int checks = 0;
  int errors = 0;
  bit exp_err = 1'b0;
  logic [CW-1:0] ch [LANES][CPW];
  logic [CW-1:0] lv [LANES];
  logic [BLK_W-1:0] exp_blk = '0;

  always #2 clk = ~clk;

  pulse_gap_rx #(.LANES(LANES), .CW(CW), .CPW(CPW)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rs_wire(rs_wire),
    .data_wire(data_wire), .blk_data(blk_data), .blk_ready(blk_ready),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < LANES; w++) lv[w] = '0;
    exp_err = 1'b0;
    exp_blk = '0;
    @(negedge clk);
    chk(blk_data == '0 && !blk_ready && !proto_err, "R11 reset state",
        {blk_data, blk_ready, proto_err}, '0);
  endtask

  // transmits the chunks in ch[][] the way a matching sender would
  task automatic run_block(input logic [1:0] md, input int bad_at);
    int ns [LANES];
    int tt [LANES][CPW];
    int t_last, t_skip, t_end, pulses;
    bit any_skip, bad_pos;
    t_last = 0; any_skip = 0; pulses = 0; bad_pos = 0;
    for (int w = 0; w < LANES; w++) begin
      ns[w] = CPW;
      if (md == 2'd1) begin
        for (int n = CPW - 1; n >= 0; n--) begin
          if (ch[w][n] == '0) ns[w] = n;
          else break;
        end
      end else if (md == 2'd2) begin
        for (int n = 0; n <= CPW; n++) begin
          bit ok;
          logic [CW-1:0] fv;
          ok = 1'b1;
          fv = (n > 0) ? ch[w][n-1] : lv[w];
          for (int k = n; k < CPW; k++) if (ch[w][k] != fv) ok = 1'b0;
          if (ok) begin ns[w] = n; break; end
        end
      end
      for (int j = 0; j < ns[w]; j++) begin
        tt[w][j] = (j == 0) ? int'(ch[w][0]) : tt[w][j-1] + int'(ch[w][j]) + 1;
        if (tt[w][j] > t_last) t_last = tt[w][j];
      end
      if (ns[w] < CPW) any_skip = 1'b1;
      for (int j = 0; j < CPW; j++) exp_blk[(w*CPW+j)*CW +: CW] = ch[w][j];
    end
    t_skip = t_last + 1;
    t_end  = any_skip ? t_skip : t_last;
    if (bad_at > 0 && md != 2'd1 && md != 2'd2) exp_err = 1'b1;
    for (int r = 0; r <= t_end + 4; r++) begin
      @(negedge clk);
      if (r > 0 && blk_ready) begin
        pulses++;
        if (r != t_end + 2) bad_pos = 1'b1;
      end
      if (r == t_end + 2)
        chk(blk_data == exp_blk, "R1 R2 R3 R5 R6 block value", blk_data, exp_blk);
      if (r == t_end + 4)
        chk(blk_data == exp_blk, "R8 block held", blk_data, exp_blk);
      if (r == 0) begin
        mode_sel = md;
        rs_wire = ~rs_wire;
      end
      for (int w = 0; w < LANES; w++)
        for (int j = 0; j < ns[w]; j++)
          if (tt[w][j] == r) data_wire[w] = ~data_wire[w];
      if (any_skip && r == t_skip) rs_wire = ~rs_wire;
      if (r == bad_at) rs_wire = ~rs_wire;
    end
    chk(pulses == 1 && !bad_pos, "R7 ready pulse", BLK_W'(pulses), BLK_W'(1));
    chk(proto_err == exp_err, "R9 R10 error flag", BLK_W'(proto_err), BLK_W'(exp_err));
    for (int w = 0; w < LANES; w++) if (ns[w] > 0) lv[w] = ch[w][ns[w]-1];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int w = 0; w < LANES; w++) lv[w] = '0;
    do_reset();

    // basic, wire 0 first chunk 0 coincides with start (R2), 15 then small (R3)
    for (int w = 0; w < LANES; w++) begin
      ch[w][0] = CW'(w);
      ch[w][1] = CW'(15 - w);
    end
    run_block(2'd0, -1);

    // zero skip: all zero, skip one cycle after start (R5)
    for (int w = 0; w < LANES; w++) begin ch[w][0] = '0; ch[w][1] = '0; end
    run_block(2'd1, -1);

    // zero skip with mixed tails (R5)
    for (int w = 0; w < LANES; w++) begin
      ch[w][0] = (w % 3 == 0) ? '0 : CW'(w);
      ch[w][1] = (w % 4 == 1) ? CW'(7) : '0;
    end
    run_block(2'd1, -1);

    // last-value: even wires repeat history, odd wires send 5 then repeat (R6)
    for (int w = 0; w < LANES; w++) begin
      if (w % 2 == 0) begin ch[w][0] = lv[w]; ch[w][1] = lv[w]; end
      else begin ch[w][0] = CW'(5); ch[w][1] = CW'(5); end
    end
    run_block(2'd2, -1);

    // random blocks in every mode (mode 3 behaves as basic, R4)
    for (int b = 0; b < 30; b++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      for (int w = 0; w < LANES; w++)
        for (int j = 0; j < CPW; j++) begin
          if ($urandom_range(0, 1) == 0 && md == 2'd1) ch[w][j] = '0;
          else if ($urandom_range(0, 1) == 0 && md == 2'd2) ch[w][j] = lv[w];
          else ch[w][j] = CW'($urandom_range(0, 15));
        end
      run_block(md, -1);
    end

    // stray data toggle while idle (R9)
    exp_blk = blk_data;
    @(negedge clk);
    data_wire[3] = ~data_wire[3];
    @(negedge clk);
    @(negedge clk);
    chk(proto_err == 1'b1, "R9 stray sets error", BLK_W'(proto_err), BLK_W'(1));
    chk(blk_data == exp_blk, "R9 stray ignored", blk_data, exp_blk);

    // reset clears everything, including last-value history (R11)
    do_reset();
    for (int w = 0; w < LANES; w++) begin ch[w][0] = '0; ch[w][1] = '0; end
    run_block(2'd2, -1);

    // basic mode premature start/skip is ignored apart from the error (R10)
    for (int w = 0; w < LANES; w++) begin ch[w][0] = CW'(8); ch[w][1] = CW'(w); end
    run_block(2'd0, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule